// File: doc/BRIEF.md
# Counter-Decoder Hardwired Control Unit

This block sequences a small accumulator processor with four instructions. It holds its state in a 4-bit counter. The counter can be cleared, loaded or incremented. A 4-to-16 decoder turns the count into one-hot state lines, and gates on those lines drive every register-transfer strobe of the datapath. Nine of the sixteen codes are used. The other seven are never entered during normal operation.

A fetch takes three states: FETCH1 at code 0, FETCH2 at code 1 and FETCH3 at code 2. In FETCH3 the counter loads an execute entry point built from the 2-bit opcode input as `1, op[1], op[0], 0`. Each execute routine is one or two states long. Its last state clears the counter back to FETCH1. The opcode input is sampled only when the counter loads. The datapath registers are outside the block.

Top module: `hw_ctrl_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the state after that edge is code 0 (FETCH1), and `state_hot` is 16'h0001.
- R2: The fetch runs code 0 to code 1 to code 2, one code per clock, whatever the opcode is.
- R3: From code 2 the next state is `{1, op[1], op[0], 0}`. That gives op 00 (add) code 8, op 01 (and) code 10, op 10 (jump) code 12 and op 11 (increment) code 14.
- R4: Code 8 steps to code 9, and code 10 steps to code 11.
- R5: Codes 9, 11, 12 and 14 return to code 0 on the next clock.
- R6: `state_hot` has exactly one bit set, at the bit position equal to `state_code`.
- R7: `pc_ld` is high only in code 12, `pc_inc` only in code 1, `ir_ld` only in code 2 and `ac_inc` only in code 14. `ac_ld` is high in codes 9 and 11.
- R8: `dr_ld`, `mem_drv` and `rd_en` are high in codes 1, 8 and 10. `pc_drv` is high only in code 0.
- R9: `ar_ld` is high in codes 0 and 2, and `dr_drv` is high in codes 2, 9, 11 and 12. `alu_and` (1 selects logical AND, 0 selects add) is high only in code 11.
- R10: In every state other than code 2, a change on `ir_op` has no effect on the state sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_op | input | 2 | Opcode held in the instruction register |
| state_code | output | 4 | Current counter value |
| state_hot | output | 16 | Decoded one-hot state |
| ar_ld | output | 1 | Address register load |
| pc_ld | output | 1 | Program counter load |
| pc_inc | output | 1 | Program counter increment |
| dr_ld | output | 1 | Data register load |
| ac_ld | output | 1 | Accumulator load from ALU |
| ac_inc | output | 1 | Accumulator increment |
| ir_ld | output | 1 | Instruction register load |
| mem_drv | output | 1 | Memory drives the internal bus |
| pc_drv | output | 1 | Program counter drives the internal bus |
| dr_drv | output | 1 | Data register drives the internal bus |
| rd_en | output | 1 | Memory read |
| alu_and | output | 1 | ALU function select |

## Verification
Strobes are decoded directly from the counter register, so they are valid in the same cycle as the state they belong to. The next state appears one clock edge after the current one. The bench drives `ir_op` and samples every output on the falling edge, so each check sees the state entered at the preceding rising edge together with that state's strobes. Opcode changes are applied on a falling edge and are judged by the state that follows the next rising edge.

// File: rtl/hw_ctrl_pkg.sv
package hw_ctrl_pkg;
  localparam int STATE_W = 4;
  localparam int OP_W    = 2;

  localparam logic [STATE_W-1:0] ST_FETCH1 = 4'd0;
  localparam logic [STATE_W-1:0] ST_FETCH2 = 4'd1;
  localparam logic [STATE_W-1:0] ST_FETCH3 = 4'd2;
  localparam logic [STATE_W-1:0] ST_ADD1   = 4'd8;
  localparam logic [STATE_W-1:0] ST_ADD2   = 4'd9;
  localparam logic [STATE_W-1:0] ST_AND1   = 4'd10;
  localparam logic [STATE_W-1:0] ST_AND2   = 4'd11;
  localparam logic [STATE_W-1:0] ST_JMP1   = 4'd12;
  localparam logic [STATE_W-1:0] ST_INC1   = 4'd14;

  typedef struct packed {
    logic ar_ld;
    logic pc_ld;
    logic pc_inc;
    logic dr_ld;
    logic ac_ld;
    logic ac_inc;
    logic ir_ld;
    logic mem_drv;
    logic pc_drv;
    logic dr_drv;
    logic rd_en;
    logic alu_and;
  } strobe_t;

  typedef struct packed {
    logic clr;
    logic ld;
    logic inc;
  } step_t;
endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic         inc,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  // clear beats load, load beats increment
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (ld)    q <= din;
    else if (inc)   q <= q + 1'b1;
  end

  p_clear_to_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));
  p_load_value_r3: assert property (@(posedge clk) disable iff (rst)
    (ld && !clr) |=> (q == $past(din)));
endmodule

// File: rtl/onehot_decoder.sv
module onehot_decoder #(
  parameter int W = 4,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] code,
  output logic [N-1:0] hot
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot[i] = (code == i[W-1:0]);
  end

  always_comb begin
    p_single_line_r6: assert ($countones(hot) == 1);
  end
endmodule

// File: rtl/strobe_logic.sv
module strobe_logic
  import hw_ctrl_pkg::*;
#(
  parameter int W  = STATE_W,
  parameter int OW = OP_W,
  localparam int N = 1 << W,
  localparam int PAD = W - OW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  hot,
  input  logic [OW-1:0] op,
  output step_t         step,
  output logic [W-1:0]  entry,
  output strobe_t       sb
);
  // execute entry point: leading one, opcode, trailing zeros
  assign entry = {1'b1, op, {PAD{1'b0}}};

  always_comb begin
    step.inc = hot[ST_FETCH1] | hot[ST_FETCH2] | hot[ST_ADD1] | hot[ST_AND1];
    step.ld  = hot[ST_FETCH3];
    // every other code, including unused ones, returns to fetch
    step.clr = ~(step.inc | step.ld);
  end

  always_comb begin
    sb.ar_ld   = hot[ST_FETCH1] | hot[ST_FETCH3];
    sb.pc_ld   = hot[ST_JMP1];
    sb.pc_inc  = hot[ST_FETCH2];
    sb.dr_ld   = hot[ST_FETCH2] | hot[ST_ADD1] | hot[ST_AND1];
    sb.ac_ld   = hot[ST_ADD2] | hot[ST_AND2];
    sb.ac_inc  = hot[ST_INC1];
    sb.ir_ld   = hot[ST_FETCH3];
    sb.mem_drv = hot[ST_FETCH2] | hot[ST_ADD1] | hot[ST_AND1];
    sb.pc_drv  = hot[ST_FETCH1];
    sb.dr_drv  = hot[ST_FETCH3] | hot[ST_ADD2] | hot[ST_AND2] | hot[ST_JMP1];
    sb.rd_en   = hot[ST_FETCH2] | hot[ST_ADD1] | hot[ST_AND1];
    sb.alu_and = hot[ST_AND2];
  end

  p_one_step_kind_r5: assert property (@(posedge clk) disable iff (rst)
    $countones({step.clr, step.ld, step.inc}) == 1);
  p_acc_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(sb.ac_ld && sb.ac_inc));
  p_single_bus_driver_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sb.mem_drv, sb.pc_drv, sb.dr_drv}));
endmodule

// File: rtl/hw_ctrl_unit.sv
module hw_ctrl_unit
  import hw_ctrl_pkg::*;
#(
  parameter int W  = STATE_W,
  parameter int OW = OP_W,
  localparam int N = 1 << W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] ir_op,
  output logic [W-1:0]  state_code,
  output logic [N-1:0]  state_hot,
  output logic          ar_ld,
  output logic          pc_ld,
  output logic          pc_inc,
  output logic          dr_ld,
  output logic          ac_ld,
  output logic          ac_inc,
  output logic          ir_ld,
  output logic          mem_drv,
  output logic          pc_drv,
  output logic          dr_drv,
  output logic          rd_en,
  output logic          alu_and
);
  step_t        step;
  strobe_t      sb;
  logic [W-1:0] entry;

  seq_counter #(.W(W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (step.clr),
    .ld  (step.ld),
    .inc (step.inc),
    .din (entry),
    .q   (state_code)
  );

  onehot_decoder #(.W(W)) u_dec (
    .code (state_code),
    .hot  (state_hot)
  );

  strobe_logic #(.W(W), .OW(OW)) u_logic (
    .clk   (clk),
    .rst   (rst),
    .hot   (state_hot),
    .op    (ir_op),
    .step  (step),
    .entry (entry),
    .sb    (sb)
  );

  assign ar_ld   = sb.ar_ld;
  assign pc_ld   = sb.pc_ld;
  assign pc_inc  = sb.pc_inc;
  assign dr_ld   = sb.dr_ld;
  assign ac_ld   = sb.ac_ld;
  assign ac_inc  = sb.ac_inc;
  assign ir_ld   = sb.ir_ld;
  assign mem_drv = sb.mem_drv;
  assign pc_drv  = sb.pc_drv;
  assign dr_drv  = sb.dr_drv;
  assign rd_en   = sb.rd_en;
  assign alu_and = sb.alu_and;

  p_reset_to_fetch_r1: assert property (@(posedge clk)
    rst |=> (state_code == ST_FETCH1));
  p_fetch_order_r2: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_FETCH2) |=> (state_code == ST_FETCH3));
  p_exec_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_FETCH3) |=> (state_code[W-1] && !state_code[0]));
  p_two_step_exec_r4: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_ADD1) |=> (state_code == ST_ADD2));
  p_jump_returns_r5: assert property (@(posedge clk) disable iff (rst)
    (state_code == ST_JMP1) |=> (state_code == ST_FETCH1));
endmodule

// File: tb/hw_ctrl_unit_test.sv
module hw_ctrl_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ir_op = 2'b00;
  logic [3:0]  state_code;
  logic [15:0] state_hot;
  logic ar_ld, pc_ld, pc_inc, dr_ld, ac_ld, ac_inc, ir_ld;
  logic mem_drv, pc_drv, dr_drv, rd_en, alu_and;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hw_ctrl_unit uut (
    .clk(clk), .rst(rst), .ir_op(ir_op),
    .state_code(state_code), .state_hot(state_hot),
    .ar_ld(ar_ld), .pc_ld(pc_ld), .pc_inc(pc_inc), .dr_ld(dr_ld),
    .ac_ld(ac_ld), .ac_inc(ac_inc), .ir_ld(ir_ld), .mem_drv(mem_drv),
    .pc_drv(pc_drv), .dr_drv(dr_drv), .rd_en(rd_en), .alu_and(alu_and)
  );

  // {op, expected state} per cycle, one full instruction of each opcode
  localparam int NV = 19;
  localparam logic [5:0] VEC [NV] = '{
    {2'b00,4'd0},{2'b00,4'd1},{2'b00,4'd2},{2'b00,4'd8},{2'b00,4'd9},
    {2'b01,4'd0},{2'b01,4'd1},{2'b01,4'd2},{2'b01,4'd10},{2'b01,4'd11},
    {2'b10,4'd0},{2'b10,4'd1},{2'b10,4'd2},{2'b10,4'd12},
    {2'b11,4'd0},{2'b11,4'd1},{2'b11,4'd2},{2'b11,4'd14},
    {2'b00,4'd0}
  };

  // expected strobes, order ar_ld pc_ld pc_inc dr_ld ac_ld ac_inc ir_ld
  // mem_drv pc_drv dr_drv rd_en alu_and (R7, R8, R9)
  function automatic logic [11:0] exp_sb(input logic [3:0] s);
    case (s)
      4'd0:    return 12'b1000_0000_1000;
      4'd1:    return 12'b0011_0001_0010;
      4'd2:    return 12'b1000_0010_0100;
      4'd8:    return 12'b0001_0001_0010;
      4'd9:    return 12'b0000_1000_0100;
      4'd10:   return 12'b0001_0001_0010;
      4'd11:   return 12'b0000_1000_0101;
      4'd12:   return 12'b0100_0000_0100;
      4'd14:   return 12'b0000_0100_0000;
      default: return 12'b0;
    endcase
  endfunction

  function automatic logic [11:0] got_sb();
    return {ar_ld, pc_ld, pc_inc, dr_ld, ac_ld, ac_inc, ir_ld,
            mem_drv, pc_drv, dr_drv, rd_en, alu_and};
  endfunction

  task automatic chk_state(input logic [3:0] exp, input string req);
    checks++;
    if (state_code !== exp) begin
      errors++;
      $display("FAIL %s state actual %0d expected %0d", req, state_code, exp);
    end
    checks++;
    if (state_hot !== (16'h1 << exp)) begin
      errors++;
      $display("FAIL R6 state_hot actual %h expected %h", state_hot, 16'h1 << exp);
    end
    checks++;
    if (got_sb() !== exp_sb(exp)) begin
      errors++;
      $display("FAIL R7/R8/R9 strobes actual %b expected %b", got_sb(), exp_sb(exp));
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk_state(4'd0, "R1");

    // table walk: R2 fetch, R3 entry, R4 steps, R5 return
    for (int i = 0; i < NV; i++) begin
      ir_op = VEC[i][5:4];
      if (i != 0) step();
      chk_state(VEC[i][3:0], "R2/R3/R4/R5");
    end

    // R10: opcode churn during fetch and execute ignored; only code 2 samples
    ir_op = 2'b10;
    step();                 // code 1
    chk_state(4'd1, "R10");
    ir_op = 2'b01;          // held through code 2
    step();
    chk_state(4'd2, "R10");
    step();                 // entry from op 01
    chk_state(4'd10, "R3");
    ir_op = 2'b11;
    step();
    chk_state(4'd11, "R10");
    ir_op = 2'b10;
    step();
    chk_state(4'd0, "R10");

    // R1: reset in mid-execute
    step(); step(); step(); // 1, 2, 12
    chk_state(4'd12, "R3");
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk_state(4'd0, "R1");
    // increment path after reset (R5)
    ir_op = 2'b11;
    step(); step(); step();
    chk_state(4'd14, "R3");
    step();
    chk_state(4'd0, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule